// File: doc/BRIEF.md
# Composite Sync Vertical Detector

This block watches a digitized, active-low composite sync signal sampled on the system clock and finds the start of each vertical interval. It measures the low time of every sync pulse and the spacing between its falling edge and the previous one. From these it sorts pulses into three kinds: line pulses (short, a full line apart), equalizing pulses (short, half a line apart) and serration pulses (long, signal mostly low). A run of equalizing pulses arms the detector. The vertical sync output is then started at the end of the first serration pulse. When no serration pulse arrives in time, a fallback timer started by the last equalizing pulse forces the output.

The vertical sync output is active low and lasts a fixed number of cycles. A one-cycle strobe marks its first cycle. All thresholds are counted in clock cycles. The pulse length and the fallback delay are both multiples of one reference count, so retuning that one parameter rescales both. Once a vertical sync has been produced, the detector ignores everything until it sees a line pulse, so the trailing equalizing and serration pulses of the same interval cannot fire it again.

Top module: `csync_vdet`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `vsync_n_o` is 1 and `vsync_start_o` is 0. Reset leaves the detector waiting for a line pulse before it can arm.
- R2: Each pulse is classified when `csync_n_i` returns high, using L, the number of clock edges that sampled it low, and P, the number of edges from the previous falling edge to its falling edge. A pulse with L < NARROW_MAX and P < HALF_MAX is equalizing. A pulse with L < NARROW_MAX and P >= HALF_MAX is a line pulse. A pulse with L > WIDE_MIN is serration. The first pulse after reset counts as a line pulse.
- R3: After an equalizing pulse has armed the detector, `vsync_n_o` goes low one clock edge after the edge that first samples `csync_n_i` high at the end of the first serration pulse.
- R4: If no serration pulse ends in time, `vsync_n_o` goes low TIMEOUT+1 edges after the edge that sampled the falling edge of the last equalizing pulse. TIMEOUT = REF_CYC*TO_MULT.
- R5: `vsync_n_o` stays low for exactly VS_LEN = REF_CYC*VS_MULT cycles. Sync pulses arriving during that time do not change the length.
- R6: `vsync_start_o` is high for exactly one cycle: the first cycle in which `vsync_n_o` is low.
- R7: A serration-length pulse that is not preceded by an equalizing pulse since the last line pulse produces no vertical sync.
- R8: After a vertical sync, further equalizing and serration pulses produce no new vertical sync until a line pulse has been seen.
- R9: Line pulses alone never produce a vertical sync. A line pulse arriving while the detector is armed disarms the equalizing phase without output, and the detector then needs a new equalizing pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| csync_n_i | input | 1 | Digitized composite sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| vsync_start_o | output | 1 | One-cycle strobe on the first low cycle of vertical sync |

## Verification
The in-module assertions check several properties on every cycle:
- the pulse kinds are mutually exclusive;
- a finished pulse always has a nonzero low count;
- the strobe coincides with the falling edge of the output and lasts one cycle;
- every start is caused by a serration end or by the fallback timer;
- the output rises only after the full count;
- arming follows a line pulse;
- a serration pulse seen while not in the equalizing phase leaves the output high.

The exact cycle of the output edge, relative to the input edges on both the serration path and the fallback path, can only be shown by the bench's scenarios. The same holds for the absence of output on plain lines, lone wide pulses, abandoned equalizing runs and repeated intervals without a line pulse, and for the effect of reset in the middle of a pulse.

// File: rtl/csvd_pkg.sv
package csvd_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_HS = 2'd0,
    ST_ARMED   = 2'd1,
    ST_EQ      = 2'd2,
    ST_VS      = 2'd3
  } vdet_state_e;

  // Both the output length and the fallback delay are multiples of one reference count.
  function automatic int unsigned ref_span(input int unsigned ref_cyc, input int unsigned mult);
    return ref_cyc * mult;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Enough bits to hold the limit plus one saturation step.
  function automatic int unsigned cnt_width(input int unsigned limit);
    return $clog2(limit + 2);
  endfunction

endpackage

// File: rtl/csvd_edge.sv
module csvd_edge #(
  parameter int unsigned CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csync_n_i,
  output logic          fall_evt,
  output logic          rise_evt,
  output logic [CW-1:0] low_cnt,
  output logic [CW-1:0] period_q
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          samp_q;
  logic          prev_q;
  logic [CW-1:0] per_cnt;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (&v) ? v : v + ONE;
  endfunction

  assign fall_evt = prev_q & ~samp_q;
  assign rise_evt = ~prev_q & samp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q   <= 1'b1;
      prev_q   <= 1'b1;
      low_cnt  <= '0;
      per_cnt  <= '1;
      period_q <= '1;
    end else begin
      samp_q <= csync_n_i;
      prev_q <= samp_q;
      if (fall_evt) begin
        low_cnt  <= ONE;
        per_cnt  <= ONE;
        period_q <= per_cnt;
      end else begin
        if (!samp_q) low_cnt <= bump(low_cnt);
        per_cnt <= bump(per_cnt);
      end
    end
  end

  // R2
  low_run_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    rise_evt |-> (low_cnt != '0));

endmodule

// File: rtl/csvd_class.sv
module csvd_class #(
  parameter int unsigned CW         = 11,
  parameter int unsigned NARROW_MAX = 64,
  parameter int unsigned WIDE_MIN   = 160,
  parameter int unsigned HALF_MAX   = 480
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_evt,
  input  logic [CW-1:0] low_cnt,
  input  logic [CW-1:0] period_q,
  output logic          eq_evt,
  output logic          hs_evt,
  output logic          ser_evt,
  output logic [CW-1:0] eq_age
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic is_narrow;
  logic is_wide;
  logic is_half;

  assign is_narrow = low_cnt < CW'(NARROW_MAX);
  assign is_wide   = low_cnt > CW'(WIDE_MIN);
  assign is_half   = period_q < CW'(HALF_MAX);

  assign eq_evt  = rise_evt & is_narrow & is_half;
  assign hs_evt  = rise_evt & is_narrow & ~is_half;
  assign ser_evt = rise_evt & is_wide;

  // Age since the falling edge of the newest equalizing pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      eq_age <= '1;
    end else if (eq_evt) begin
      eq_age <= low_cnt + ONE;
    end else if (!(&eq_age)) begin
      eq_age <= eq_age + ONE;
    end
  end

  // R2
  pulse_kind_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({eq_evt, hs_evt, ser_evt}));

endmodule

// File: rtl/csvd_seq.sv
module csvd_seq
  import csvd_pkg::*;
#(
  parameter int unsigned CW      = 11,
  parameter int unsigned VS_LEN  = 1920,
  parameter int unsigned TIMEOUT = 620
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eq_evt,
  input  logic          hs_evt,
  input  logic          ser_evt,
  input  logic [CW-1:0] eq_age,
  output logic          vs_n_o,
  output logic          vs_start_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  vdet_state_e   state_q;
  vdet_state_e   state_d;
  logic [CW-1:0] vs_cnt_q;
  logic          vs_n_q;
  logic          vs_start_q;
  logic          timeout_evt;
  logic          start_evt;
  logic          vs_done;

  assign timeout_evt = (state_q == ST_EQ) && (eq_age == CW'(TIMEOUT));
  assign start_evt   = (state_q == ST_EQ) && (ser_evt || timeout_evt);
  assign vs_done     = (state_q == ST_VS) && (vs_cnt_q == CW'(VS_LEN));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_HS: if (hs_evt) state_d = ST_ARMED;
      ST_ARMED:   if (eq_evt) state_d = ST_EQ;
      ST_EQ: begin
        if (start_evt)   state_d = ST_VS;
        else if (hs_evt) state_d = ST_ARMED;
      end
      ST_VS:      if (vs_done) state_d = ST_WAIT_HS;
      default:    state_d = ST_WAIT_HS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_WAIT_HS;
      vs_cnt_q   <= '0;
      vs_n_q     <= 1'b1;
      vs_start_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      vs_start_q <= start_evt;
      if (start_evt) begin
        vs_cnt_q <= ONE;
        vs_n_q   <= 1'b0;
      end else if (vs_done) begin
        vs_n_q <= 1'b1;
      end else if (state_q == ST_VS) begin
        vs_cnt_q <= vs_cnt_q + ONE;
      end
    end
  end

  assign vs_n_o     = vs_n_q;
  assign vs_start_o = vs_start_q;

  // R5
  vs_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vs_n_q) |-> ($past(vs_cnt_q) == CW'(VS_LEN)));

  // R3 R4
  start_cause_chk: assert property (@(posedge clk) disable iff (rst)
    vs_start_q |-> ($past(ser_evt) || ($past(eq_age) == CW'(TIMEOUT))));

  // R8
  rearm_needs_hs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == ST_ARMED) |-> $past(hs_evt));

  // R7
  no_start_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_evt && state_q == ST_ARMED) |=> vs_n_q);

endmodule

// File: rtl/csync_vdet.sv
module csync_vdet
  import csvd_pkg::*;
#(
  parameter int unsigned NARROW_MAX = 64,
  parameter int unsigned WIDE_MIN   = 160,
  parameter int unsigned HALF_MAX   = 480,
  parameter int unsigned REF_CYC    = 20,
  parameter int unsigned VS_MULT    = 96,
  parameter int unsigned TO_MULT    = 31
) (
  input  logic clk,
  input  logic rst,
  input  logic csync_n_i,
  output logic vsync_n_o,
  output logic vsync_start_o
);
  localparam int unsigned VS_LEN  = ref_span(REF_CYC, VS_MULT);
  localparam int unsigned TIMEOUT = ref_span(REF_CYC, TO_MULT);
  localparam int unsigned LIMIT   = max2(max2(VS_LEN, TIMEOUT), max2(HALF_MAX, WIDE_MIN + 1));
  localparam int unsigned CW      = cnt_width(LIMIT);

  logic          fall_evt;
  logic          rise_evt;
  logic [CW-1:0] low_cnt;
  logic [CW-1:0] period_q;
  logic          eq_evt;
  logic          hs_evt;
  logic          ser_evt;
  logic [CW-1:0] eq_age;

  csvd_edge #(.CW(CW)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .csync_n_i (csync_n_i),
    .fall_evt  (fall_evt),
    .rise_evt  (rise_evt),
    .low_cnt   (low_cnt),
    .period_q  (period_q)
  );

  csvd_class #(
    .CW         (CW),
    .NARROW_MAX (NARROW_MAX),
    .WIDE_MIN   (WIDE_MIN),
    .HALF_MAX   (HALF_MAX)
  ) u_class (
    .clk      (clk),
    .rst      (rst),
    .rise_evt (rise_evt),
    .low_cnt  (low_cnt),
    .period_q (period_q),
    .eq_evt   (eq_evt),
    .hs_evt   (hs_evt),
    .ser_evt  (ser_evt),
    .eq_age   (eq_age)
  );

  csvd_seq #(
    .CW      (CW),
    .VS_LEN  (VS_LEN),
    .TIMEOUT (TIMEOUT)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .eq_evt     (eq_evt),
    .hs_evt     (hs_evt),
    .ser_evt    (ser_evt),
    .eq_age     (eq_age),
    .vs_n_o     (vsync_n_o),
    .vs_start_o (vsync_start_o)
  );

  // R6
  strobe_align_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync_n_o) |-> vsync_start_o);

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    vsync_start_o |=> !vsync_start_o);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (vsync_n_o && !vsync_start_o));

endmodule

// File: tb/sim_csync_vdet.sv
module sim_csync_vdet;
  localparam int LINE   = 640;
  localparam int HALF   = 320;
  localparam int HS_LO  = 48;
  localparam int EQ_LO  = 24;
  localparam int SER_LO = 272;
  localparam int NMAX   = 64;
  localparam int WMIN   = 160;
  localparam int HMAX   = 480;
  localparam int REFC   = 20;
  localparam int VSL    = REFC * 96;
  localparam int TOUT   = REFC * 31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csync_n = 1'b1;
  logic vsync_n;
  logic vsync_start;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  int n_vs, fall_cyc, cur_w, last_w, n_strobe, strobe_cyc, strobe_multi;
  bit vs_prev = 1'b1;
  bit st_prev = 1'b0;
  int first_ser_rise, last_eq_fall;

  csync_vdet #(
    .NARROW_MAX (NMAX),
    .WIDE_MIN   (WMIN),
    .HALF_MAX   (HMAX),
    .REF_CYC    (REFC),
    .VS_MULT    (96),
    .TO_MULT    (31)
  ) u0 (
    .clk           (clk),
    .rst           (rst),
    .csync_n_i     (csync_n),
    .vsync_n_o     (vsync_n),
    .vsync_start_o (vsync_start)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Output monitor, sampled between clock edges.
  always @(negedge clk) begin
    if (vs_prev && !vsync_n) begin
      n_vs     <= n_vs + 1;
      fall_cyc <= cyc;
      cur_w    <= 1;
    end else if (!vsync_n) begin
      cur_w <= cur_w + 1;
    end else if (!vs_prev) begin
      last_w <= cur_w;
    end
    if (vsync_start) begin
      n_strobe   <= n_strobe + 1;
      strobe_cyc <= cyc;
      if (st_prev) strobe_multi <= 1;
    end
    vs_prev <= vsync_n;
    st_prev <= vsync_start;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk);
    n_vs = 0; fall_cyc = -1; last_w = -1; n_strobe = 0; strobe_cyc = -2; strobe_multi = 0;
  endtask

  task automatic pulse(input int lo, input int per);
    @(negedge clk);
    csync_n = 1'b0;
    last_eq_fall = cyc;
    repeat (lo) @(negedge clk);
    csync_n = 1'b1;
    if (first_ser_rise < 0 && lo > WMIN) first_ser_rise = cyc;
    repeat (per - lo - 1) @(negedge clk);
  endtask

  task automatic lines(input int k);
    for (int i = 0; i < k; i++) pulse(HS_LO, LINE);
  endtask

  task automatic eqs(input int k);
    for (int i = 0; i < k; i++) pulse(EQ_LO, HALF);
  endtask

  task automatic sers(input int k);
    for (int i = 0; i < k; i++) pulse(SER_LO, HALF);
  endtask

  task automatic vinterval();
    first_ser_rise = -1;
    eqs(6); sers(6); eqs(6);
  endtask

  task automatic check_one_vs(input string tag, input int exp_fall);
    check(n_vs == 1, tag, n_vs, 1);
    check(fall_cyc == exp_fall, tag, fall_cyc, exp_fall);
    check(last_w == VSL, "R5 width", last_w, VSL);
    check(n_strobe == 1 && strobe_multi == 0, "R6 strobe count", n_strobe, 1);
    check(strobe_cyc == fall_cyc, "R6 strobe position", strobe_cyc, fall_cyc);
  endtask

  // R1: outputs idle in and right after reset.
  task automatic t_reset();
    repeat (4) @(negedge clk);
    check(vsync_n == 1'b1, "R1 vs_n in reset", vsync_n, 1);
    check(vsync_start == 1'b0, "R1 strobe in reset", vsync_start, 0);
    rst = 1'b0;
    @(negedge clk);
    check(vsync_n == 1'b1, "R1 vs_n after reset", vsync_n, 1);
  endtask

  // R3 R5 R6: field starting on a full line.
  task automatic t_field_a();
    clear_mon();
    lines(3); vinterval(); lines(4);
    check_one_vs("R3 field A", first_ser_rise + 2);
  endtask

  // R3 R2: field starting half a line late (interlaced).
  task automatic t_field_b();
    clear_mon();
    lines(3); pulse(HS_LO, HALF); vinterval(); lines(4);
    check_one_vs("R3 field B", first_ser_rise + 2);
  endtask

  // R4: no serration pulses, one long low instead.
  task automatic t_no_serration();
    int eqf;
    clear_mon();
    lines(3); eqs(6);
    eqf = last_eq_fall;
    pulse(1900, 1920); eqs(6); lines(4);
    check_one_vs("R4 forced", eqf + TOUT + 2);
  endtask

  // R9: plain lines only.
  task automatic t_lines_only();
    clear_mon();
    lines(10);
    check(n_vs == 0, "R9 lines only", n_vs, 0);
    check(vsync_n == 1'b1, "R9 vs_n idle", vsync_n, 1);
  endtask

  // R7: wide pulse with no equalizing pulse before it.
  task automatic t_lone_wide();
    clear_mon();
    lines(3); pulse(SER_LO, LINE); pulse(SER_LO, LINE); lines(3);
    check(n_vs == 0, "R7 lone wide", n_vs, 0);
  endtask

  // R9: equalizing run abandoned by a line pulse, then a real interval still works.
  task automatic t_abandon();
    clear_mon();
    lines(3); eqs(2); pulse(EQ_LO, 500); lines(3);
    check(n_vs == 0, "R9 abandoned run", n_vs, 0);
    clear_mon();
    vinterval(); lines(4);
    check(n_vs == 1, "R9 armed after abandon", n_vs, 1);
  endtask

  // R8: second interval with no line pulse between is ignored.
  task automatic t_rearm();
    int first_fall;
    clear_mon();
    lines(3); vinterval();
    first_fall = first_ser_rise + 2;
    vinterval(); lines(4);
    check(n_vs == 1, "R8 no retrigger", n_vs, 1);
    check(fall_cyc == first_fall, "R8 single start", fall_cyc, first_fall);
    clear_mon();
    vinterval(); lines(4);
    check(n_vs == 1, "R8 rearmed by line", n_vs, 1);
  endtask

  // R1: reset in the middle of a vertical sync.
  task automatic t_reset_mid();
    clear_mon();
    lines(3); first_ser_rise = -1; eqs(6); sers(2);
    check(vsync_n == 1'b0, "R1 vs active before reset", vsync_n, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(vsync_n == 1'b1, "R1 vs_n cleared by reset", vsync_n, 1);
    check(vsync_start == 1'b0, "R1 strobe cleared by reset", vsync_start, 0);
    rst = 1'b0;
    clear_mon();
    sers(4); eqs(6);
    check(n_vs == 0, "R1 disarmed after reset", n_vs, 0);
    lines(2);
  endtask

  initial begin
    first_ser_rise = -1;
    last_eq_fall = 0;
    t_reset();
    t_field_a();
    t_field_b();
    t_no_serration();
    t_lines_only();
    t_lone_wide();
    t_abandon();
    t_rearm();
    t_reset_mid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule